// File: doc/BRIEF.md
# Channel Nesting Level Controller

This block decides which interrupt channels may still reach each host interrupt line while an interrupt is being serviced. Every host line gets a 32-bit allow mask, one bit per channel. Channel 0 has the highest priority, and a channel is allowed only when its number is strictly below the nesting level in force. A separate prioritizer, which is not part of this block, combines the mask with the pending channels.

A two-bit mode input sets the scope of nesting. In one mode, a single shared level gates every host line. In another mode, each host line has its own level. In the remaining codes, nesting is turned off.

When an interrupt is taken, a strobe carries the host line and the channel. The block saves the current level on a small LIFO and raises nesting to that channel. A completion strobe pops the saved level back. Software can write any level register directly, which overrides its value and discards its saved history. Every level register can be read back on the output ports.

Top module: `nest_ctrl`

## Requirements
- R1: After reset, the global level and every host level read 32, and every allow mask is all ones.
- R2: In a nesting mode, bit c of host n's allow mask is 1 exactly when c is strictly less than host n's effective level. The effective level is the global level in global mode and host n's own level in per-host mode. The mask follows a level change one cycle after the strobe or write that caused it.
- R3: The mode encoding is 0 = off, 1 = global, 2 = per-host, and 3 = reserved. In modes 0 and 3, every mask bit is 1 whatever the stored levels are.
- R4: In mode 1, a take strobe on either host line sets the global level to the taken channel on the next cycle. The host levels are left unchanged, and both masks follow the global level.
- R5: In mode 2, a take strobe on host n sets only host n's level to the channel. The other host's level and the global level are unchanged.
- R6: A completion strobe in mode 1 (global register) or mode 2 (register of the named host) restores the level held before the most recent unreturned take, in LIFO order, for up to 4 nested takes.
- R7: Each level register saves at most 4 previous levels. A fifth nested take drops the oldest saved value. A completion with no saved value sets the level to 32.
- R8: A software write goes to the global level when the select is 0 and to host n's level when the select is n+1. It takes effect on the next cycle and clears that register's saved history. A value above 32 is stored as 32.
- R9: When a take and a completion hit the same register in the same cycle, the take is applied and the completion is ignored. A software write to a register overrides both strobes for that register.
- R10: In modes 0 and 3, take and completion strobes change no level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Nesting mode: 0 off, 1 global, 2 per-host, 3 reserved (off) |
| take_i | input | 1 | Interrupt-taken strobe |
| take_host_i | input | 1 | Host line of the taken interrupt |
| take_chan_i | input | 5 | Channel of the taken interrupt |
| done_i | input | 1 | Service-complete strobe |
| done_host_i | input | 1 | Host line whose service completed |
| lvl_wr_i | input | 1 | Software level write strobe |
| lvl_wr_sel_i | input | 2 | Write target: 0 global, n+1 host n |
| lvl_wr_data_i | input | 6 | Level value to write |
| glb_level_o | output | 6 | Current global nesting level |
| host_level_o | output | 12 | Current per-host levels, host n at bits [6n+5:6n] |
| allow_mask_o | output | 64 | Per-host channel allow masks, host n at bits [32n+31:32n] |

## Verification
The assertions assume that the channel on a take strobe is below the channel count. They also assume that a mode change applies to the masks within the same cycle, so mask checks are made against the mode present at that moment. The stimulus draws channels only from 0 to 31 and write data from 0 to 39, so the clamp on writes is exercised while strobes stay in range. Mode changes are rare and random. Directed sequences cover the deep stacking, underflow, same-cycle collision and disabled-mode cases.

// File: rtl/nest_pkg.sv
package nest_pkg;
    typedef enum logic [1:0] {
        NEST_OFF      = 2'd0,
        NEST_GLOBAL   = 2'd1,
        NEST_PER_HOST = 2'd2,
        NEST_RSVD     = 2'd3
    } nest_mode_e;
endpackage

// File: rtl/nest_lvl_reg.sv
// One nesting level register with a LIFO of previously held levels.
module nest_lvl_reg #(
    parameter int NUM_CH = 32,
    parameter int DEPTH  = 4,
    parameter int LW     = $clog2(NUM_CH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [LW-1:0] push_lvl_i,
    input  logic          wr_i,
    input  logic [LW-1:0] wr_lvl_i,
    output logic [LW-1:0] level_o
);
    localparam logic [LW-1:0] IDLE = LW'(NUM_CH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [LW-1:0]             lvl;
        logic [CW-1:0]             cnt;
        logic [DEPTH-1:0][LW-1:0]  stk;
    } lvl_state_t;

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            // software override wins and forgets history
            st_d.lvl = (wr_lvl_i > IDLE) ? IDLE : wr_lvl_i;
            st_d.cnt = '0;
            for (int i = 0; i < DEPTH; i++) st_d.stk[i] = IDLE;
        end else if (push_i) begin
            st_d.lvl = (push_lvl_i > IDLE) ? IDLE : push_lvl_i;
            for (int i = DEPTH - 1; i > 0; i--) st_d.stk[i] = st_q.stk[i-1];
            st_d.stk[0] = st_q.lvl;
            if (st_q.cnt != CW'(DEPTH)) st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop_i) begin
            if (st_q.cnt == '0) begin
                st_d.lvl = IDLE;
            end else begin
                st_d.lvl = st_q.stk[0];
                st_d.cnt = st_q.cnt - 1'b1;
            end
            for (int i = 0; i < DEPTH - 1; i++) st_d.stk[i] = st_q.stk[i+1];
            st_d.stk[DEPTH-1] = IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= IDLE;
            st_q.cnt <= '0;
            st_q.stk <= {DEPTH{IDLE}};
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.lvl;

    p_level_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= IDLE);
    p_push_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !wr_i && push_lvl_i <= IDLE) |=> level_o == $past(push_lvl_i));
    p_wr_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wr_lvl_i <= IDLE) |=> level_o == $past(wr_lvl_i));
    p_wr_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wr_lvl_i > IDLE) |=> level_o == IDLE);
    p_pop_empty_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !wr_i && st_q.cnt == '0) |=> level_o == IDLE);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_i && !push_i && !wr_i) |=> $stable(level_o));
endmodule

// File: rtl/nest_mask_gen.sv
// Expands a nesting level into a per-channel allow mask.
module nest_mask_gen #(
    parameter int NUM_CH = 32,
    parameter int LW     = $clog2(NUM_CH + 1)
) (
    input  logic              enable_i,
    input  logic [LW-1:0]     level_i,
    output logic [NUM_CH-1:0] mask_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [LW-1:0] CV = LW'(c);
        assign mask_o[c] = !enable_i || (CV < level_i);
    end
endmodule

// File: rtl/nest_ctrl.sv
module nest_ctrl
    import nest_pkg::*;
#(
    parameter int NUM_HOSTS = 2,
    parameter int NUM_CH    = 32,
    parameter int DEPTH     = 4,
    localparam int LW  = $clog2(NUM_CH + 1),
    localparam int CHW = $clog2(NUM_CH),
    localparam int HW  = (NUM_HOSTS > 1) ? $clog2(NUM_HOSTS) : 1,
    localparam int SW  = $clog2(NUM_HOSTS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  mode_i,
    input  logic                        take_i,
    input  logic [HW-1:0]               take_host_i,
    input  logic [CHW-1:0]              take_chan_i,
    input  logic                        done_i,
    input  logic [HW-1:0]               done_host_i,
    input  logic                        lvl_wr_i,
    input  logic [SW-1:0]               lvl_wr_sel_i,
    input  logic [LW-1:0]               lvl_wr_data_i,
    output logic [LW-1:0]               glb_level_o,
    output logic [NUM_HOSTS*LW-1:0]     host_level_o,
    output logic [NUM_HOSTS*NUM_CH-1:0] allow_mask_o
);
    nest_mode_e    mode;
    logic          is_glb, is_host, nest_en;
    logic [LW-1:0] take_lvl;

    always_comb begin
        mode     = nest_mode_e'(mode_i);
        is_glb   = (mode == NEST_GLOBAL);
        is_host  = (mode == NEST_PER_HOST);
        nest_en  = is_glb || is_host;
        take_lvl = LW'(take_chan_i);
    end

    // shared level
    nest_lvl_reg #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .LW(LW)) u_glb (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take_i && is_glb),
        .pop_i      (done_i && is_glb),
        .push_lvl_i (take_lvl),
        .wr_i       (lvl_wr_i && (lvl_wr_sel_i == '0)),
        .wr_lvl_i   (lvl_wr_data_i),
        .level_o    (glb_level_o)
    );

    for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_host
        logic [LW-1:0]     hlvl;
        logic [LW-1:0]     eff_lvl;
        logic [NUM_CH-1:0] hmask;

        nest_lvl_reg #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .LW(LW)) u_lvl (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_i     (take_i && is_host && (take_host_i == HW'(h))),
            .pop_i      (done_i && is_host && (done_host_i == HW'(h))),
            .push_lvl_i (take_lvl),
            .wr_i       (lvl_wr_i && (lvl_wr_sel_i == SW'(h + 1))),
            .wr_lvl_i   (lvl_wr_data_i),
            .level_o    (hlvl)
        );

        assign eff_lvl = is_glb ? glb_level_o : hlvl;

        nest_mask_gen #(.NUM_CH(NUM_CH), .LW(LW)) u_mask (
            .enable_i (nest_en),
            .level_i  (eff_lvl),
            .mask_o   (hmask)
        );

        assign host_level_o[h*LW +: LW]     = hlvl;
        assign allow_mask_o[h*NUM_CH +: NUM_CH] = hmask;

        p_mask_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
            nest_en |-> ($countones(hmask) == int'(eff_lvl)));
        p_off_all_allowed_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !nest_en |-> (&hmask));
    end

    p_glb_keeps_hosts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_glb && !lvl_wr_i) |=> $stable(host_level_o));
    p_host_keeps_glb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_host && !(lvl_wr_i && lvl_wr_sel_i == '0)) |=> $stable(glb_level_o));
    p_off_levels_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_en && !lvl_wr_i) |=> ($stable(glb_level_o) && $stable(host_level_o)));
endmodule

// File: tb/tb_nest_ctrl.sv
module tb_nest_ctrl;
    localparam int NH = 2, NC = 32, DP = 4, LW = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n;
    logic [1:0]       mode_i;
    logic             take_i, done_i, lvl_wr_i;
    logic [0:0]       take_host_i, done_host_i;
    logic [4:0]       take_chan_i;
    logic [1:0]       lvl_wr_sel_i;
    logic [LW-1:0]    lvl_wr_data_i;
    logic [LW-1:0]    glb_level_o;
    logic [NH*LW-1:0] host_level_o;
    logic [NH*NC-1:0] allow_mask_o;

    nest_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .take_i(take_i), .take_host_i(take_host_i), .take_chan_i(take_chan_i),
        .done_i(done_i), .done_host_i(done_host_i),
        .lvl_wr_i(lvl_wr_i), .lvl_wr_sel_i(lvl_wr_sel_i), .lvl_wr_data_i(lvl_wr_data_i),
        .glb_level_o(glb_level_o), .host_level_o(host_level_o), .allow_mask_o(allow_mask_o)
    );

    int checks = 0, fails = 0;
    int mlvl[3];
    int mstk[3][DP];
    int mcnt[3];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_mask(int lvl);
        logic [31:0] m;
        for (int c = 0; c < 32; c++) m[c] = (c < lvl);
        return m;
    endfunction

    task automatic m_reset();
        for (int r = 0; r < 3; r++) begin
            mlvl[r] = 32; mcnt[r] = 0;
            for (int i = 0; i < DP; i++) mstk[r][i] = 32;
        end
    endtask

    task automatic m_push(int r, int v);
        for (int i = DP - 1; i > 0; i--) mstk[r][i] = mstk[r][i-1];
        mstk[r][0] = mlvl[r];
        mlvl[r] = v;
        if (mcnt[r] < DP) mcnt[r]++;
    endtask

    task automatic m_pop(int r);
        if (mcnt[r] == 0) mlvl[r] = 32;
        else begin mlvl[r] = mstk[r][0]; mcnt[r]--; end
        for (int i = 0; i < DP - 1; i++) mstk[r][i] = mstk[r][i+1];
        mstk[r][DP-1] = 32;
    endtask

    task automatic m_write(int r, int d);
        mlvl[r] = (d > 32) ? 32 : d;
        mcnt[r] = 0;
        for (int i = 0; i < DP; i++) mstk[r][i] = 32;
    endtask

    task automatic check_all(string tag);
        for (int h = 0; h < NH; h++) begin
            int eff;
            eff = (mode_i == 2'd1) ? mlvl[0] : (mode_i == 2'd2) ? mlvl[h+1] : 32;
            chk(tag, 64'(host_level_o[h*LW +: LW]), 64'(mlvl[h+1]));
            chk(tag, 64'(allow_mask_o[h*NC +: NC]), 64'(exp_mask(eff)));
        end
        chk(tag, 64'(glb_level_o), 64'(mlvl[0]));
    endtask

    // inputs are set at a negedge; this advances one edge and checks
    task automatic step(string tag);
        bit push[3], pop[3], wr[3];
        for (int r = 0; r < 3; r++) begin
            wr[r]   = lvl_wr_i && (int'(lvl_wr_sel_i) == r);
            push[r] = take_i && ((r == 0) ? (mode_i == 2'd1)
                                : (mode_i == 2'd2 && int'(take_host_i) == r - 1));
            pop[r]  = done_i && ((r == 0) ? (mode_i == 2'd1)
                                : (mode_i == 2'd2 && int'(done_host_i) == r - 1));
        end
        @(posedge clk);
        for (int r = 0; r < 3; r++) begin
            if (wr[r]) m_write(r, int'(lvl_wr_data_i));
            else if (push[r]) m_push(r, int'(take_chan_i));
            else if (pop[r]) m_pop(r);
        end
        @(negedge clk);
        check_all(tag);
        take_i = 0; done_i = 0; lvl_wr_i = 0;
    endtask

    task automatic take(int h, int ch, string tag);
        take_i = 1; take_host_i = 1'(h); take_chan_i = 5'(ch); step(tag);
    endtask
    task automatic done(int h, string tag);
        done_i = 1; done_host_i = 1'(h); step(tag);
    endtask
    task automatic wr(int sel, int d, string tag);
        lvl_wr_i = 1; lvl_wr_sel_i = 2'(sel); lvl_wr_data_i = 6'(d); step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        rst_n = 0; mode_i = 0; take_i = 0; done_i = 0; lvl_wr_i = 0;
        take_host_i = 0; done_host_i = 0; take_chan_i = 0;
        lvl_wr_sel_i = 0; lvl_wr_data_i = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        mode_i = 2'd1;
        @(negedge clk);
        check_all("R1 reset");

        // per-host nesting and LIFO restore
        mode_i = 2'd2;
        take(0, 5, "R5 take host0 ch5");
        chk("R2 mask host0 lvl5", 64'(allow_mask_o[31:0]), 64'h1f);
        take(0, 3, "R5 nested take");
        done(0, "R6 restore 5");
        done(0, "R6 restore idle");
        take(1, 0, "R5 host1 ch0 blocks all");
        chk("R2 host1 mask zero", 64'(allow_mask_o[63:32]), 64'h0);
        done(1, "R6 host1 restore");

        // global mode, overflow and underflow
        mode_i = 2'd1;
        take(0, 10, "R4 global take"); take(1, 9, "R4 global take other host");
        take(0, 8, "R4"); take(1, 7, "R4"); take(0, 6, "R7 fifth take");
        done(0, "R7 pop 7"); done(1, "R7 pop 8"); done(0, "R7 pop 9");
        done(1, "R7 pop 10");
        done(0, "R7 underflow idle");
        chk("R7 idle level", 64'(glb_level_o), 64'd32);

        // software override
        take(0, 4, "R8 pre-write take");
        wr(0, 20, "R8 write global");
        done(0, "R8 history cleared");
        wr(0, 50, "R8 clamp");
        wr(2, 7, "R8 write host1");

        // same-cycle collisions
        take_i = 1; take_host_i = 0; take_chan_i = 12; done_i = 1; done_host_i = 1;
        step("R9 take beats complete");
        take_i = 1; take_chan_i = 2; lvl_wr_i = 1; lvl_wr_sel_i = 0; lvl_wr_data_i = 25;
        step("R9 write beats take");

        // disabled modes
        wr(0, 3, "R3 set low global");
        mode_i = 2'd0;
        @(negedge clk); check_all("R3 mode0 all allowed");
        take(0, 1, "R10 mode0 take ignored");
        done(0, "R10 mode0 done ignored");
        mode_i = 2'd3;
        @(negedge clk); check_all("R3 mode3 all allowed");
        take(1, 1, "R10 mode3 take ignored");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 20 == 0) mode_i = 2'($urandom % 4);
            take_i = ($urandom % 3 == 0);
            take_host_i = 1'($urandom % 2);
            take_chan_i = 5'($urandom % 32);
            done_i = ($urandom % 3 == 0);
            done_host_i = 1'($urandom % 2);
            lvl_wr_i = ($urandom % 16 == 0);
            lvl_wr_sel_i = 2'($urandom % 3);
            lvl_wr_data_i = 6'($urandom % 40);
            step("R2 R6 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule